// File: doc/BRIEF.md
# Single-Cycle 32-Register Load/Store Core

This block is a compact processor core that completes one fixed-length 32-bit instruction in each clock cycle. It holds a program counter and thirty-two 32-bit general registers. Register 31 is a constant zero. One arithmetic unit adds, subtracts or multiplies. Its second operand is either a register or a sign-extended 16-bit constant. The same unit computes load and store addresses. Instruction storage and data storage are word arrays inside the block. Addresses are byte addresses, and the two low bits select nothing.

The program is written into instruction storage through a valid/ready stream while the core is held in reset. `load_ready` is high only during reset, so the loader has to wait for it. A word is accepted on every clock edge where `load_valid` and `load_ready` are both high, and the loader may leave `load_valid` high to stream words back to back. Once reset is released, `load_ready` stays low and further words are refused.

The outcome of each instruction is reported on plain pins in the cycle it executes: the current PC, the register write it commits and the store it performs.

Top module: `word_core`

## Requirements
- R1: An instruction splits into an opcode in bits 31..26, a destination `rc` in 25..21, a source `ra` in 20..16, and either a register `rb` in 15..11 or a signed constant in 15..0. The word 0x80611000 adds r1 and r2 into r3.
- R2: Register forms: 100000 writes ra+rb, 100001 writes ra-rb and 100010 writes the low 32 bits of ra*rb, each into rc.
- R3: Constant forms: 110000, 110001 and 110010 perform the same three operations with the sign-extended 16-bit constant in place of rb.
- R4: Register 31 reads as zero, and any write aimed at it is dropped. `wb_en` stays low for such a write.
- R5: Load (011000) writes rc from the data word at byte address Reg[ra]+sext(constant). Store (011001) writes Reg[rc] to that address and shows it on `st_en`, `st_addr` and `st_data`.
- R6: Reset sets the PC to 0. Every instruction that is not a taken branch or a jump advances the PC by 4.
- R7: Branch-if-zero (011100) and branch-if-nonzero (011101) write PC+4 into rc. When their condition on Reg[ra] holds, the next PC is PC+4+4*offset, where offset is the signed 16-bit field.
- R8: Jump (011011) writes PC+4 into rc and takes its next PC from Reg[ra] with bits 1..0 forced to zero.
- R9: An opcode outside the eleven listed performs no register write and no store, and advances the PC by 4.
- R10: `load_ready` is high exactly while `rst` is high. A word is written into instruction storage on each edge where `load_valid` and `load_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also opens program loading |
| load_valid | input | 1 | Program word offered |
| load_ready | output | 1 | Program word may be accepted (reset only) |
| load_addr | input | $clog2(IMEM_WORDS) | Word index of the offered program word |
| load_data | input | 32 | Program word |
| pc | output | 32 | Byte address of the executing instruction |
| wb_en | output | 1 | A register write commits this cycle |
| wb_idx | output | 5 | Destination register of the write |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | A store commits this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Value stored |

## Verification
The assertions assume that the program is loaded before reset is released. They also assume that every load, store and jump address falls inside the arrays, because the word index quietly drops the upper address bits. The bench loads only while reset is held. Its program keeps every memory address and jump target small. It ends in a branch that loops on itself, so the PC never leaves the loaded words.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam logic [5:0] OP_LD   = 6'b011000;
  localparam logic [5:0] OP_ST   = 6'b011001;
  localparam logic [5:0] OP_JMP  = 6'b011011;
  localparam logic [5:0] OP_BEQ  = 6'b011100;
  localparam logic [5:0] OP_BNE  = 6'b011101;
  localparam logic [5:0] OP_ADD  = 6'b100000;
  localparam logic [5:0] OP_SUB  = 6'b100001;
  localparam logic [5:0] OP_MUL  = 6'b100010;
  localparam logic [5:0] OP_ADDC = 6'b110000;
  localparam logic [5:0] OP_SUBC = 6'b110001;
  localparam logic [5:0] OP_MULC = 6'b110010;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_MUL} alu_fn_e;

  typedef struct packed {
    logic    reg_we;
    logic    use_const;
    logic    mem_rd;
    logic    mem_wr;
    logic    is_br;
    logic    br_on_zero;
    logic    is_jmp;
    logic    rb_is_rc;
    logic    legal;
    alu_fn_e fn;
  } ctrl_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] op,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{reg_we: 1'b0, use_const: 1'b1, mem_rd: 1'b0, mem_wr: 1'b0,
            is_br: 1'b0, br_on_zero: 1'b0, is_jmp: 1'b0, rb_is_rc: 1'b0,
            legal: 1'b1, fn: FN_ADD};
    case (op)
      OP_ADD:  begin ctl.reg_we = 1'b1; ctl.use_const = 1'b0; end
      OP_SUB:  begin ctl.reg_we = 1'b1; ctl.use_const = 1'b0; ctl.fn = FN_SUB; end
      OP_MUL:  begin ctl.reg_we = 1'b1; ctl.use_const = 1'b0; ctl.fn = FN_MUL; end
      OP_ADDC: ctl.reg_we = 1'b1;
      OP_SUBC: begin ctl.reg_we = 1'b1; ctl.fn = FN_SUB; end
      OP_MULC: begin ctl.reg_we = 1'b1; ctl.fn = FN_MUL; end
      OP_LD:   begin ctl.reg_we = 1'b1; ctl.mem_rd = 1'b1; end
      OP_ST:   begin ctl.mem_wr = 1'b1; ctl.rb_is_rc = 1'b1; end
      OP_BEQ:  begin ctl.reg_we = 1'b1; ctl.is_br = 1'b1; ctl.br_on_zero = 1'b1; end
      OP_BNE:  begin ctl.reg_we = 1'b1; ctl.is_br = 1'b1; end
      OP_JMP:  begin ctl.reg_we = 1'b1; ctl.is_jmp = 1'b1; end
      default: ctl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      FN_SUB:  y = a - b;
      FN_MUL:  y = a * b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int ZIDX = NREGS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en && wr_idx != AW'(ZIDX)) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_a = (rd_a_idx == AW'(ZIDX)) ? '0 : regs[rd_a_idx];
  assign rd_b = (rd_b_idx == AW'(ZIDX)) ? '0 : regs[rd_b_idx];
endmodule

// File: rtl/word_core.sv
module word_core
  import core_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_valid,
  output logic                          load_ready,
  input  logic [$clog2(IMEM_WORDS)-1:0] load_addr,
  input  logic [31:0]                   load_data,
  output logic [XLEN-1:0]               pc,
  output logic                          wb_en,
  output logic [4:0]                    wb_idx,
  output logic [XLEN-1:0]               wb_data,
  output logic                          st_en,
  output logic [XLEN-1:0]               st_addr,
  output logic [XLEN-1:0]               st_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [31:0]     instr;
  logic [5:0]      op;
  logic [4:0]      rc_f, ra_f, rb_f;
  logic [XLEN-1:0] imm, ra_val, rb_val, alu_b, alu_y, pc_plus4, pc_next, ld_val;
  logic            taken;
  ctrl_t           ctl;

  assign load_ready = rst;

  always_ff @(posedge clk) begin
    if (load_valid && load_ready) imem[load_addr] <= load_data;
  end

  assign instr = imem[pc[IAW+1:2]];
  assign op    = instr[31:26];
  assign rc_f  = instr[25:21];
  assign ra_f  = instr[20:16];
  assign rb_f  = instr[15:11];
  assign imm   = {{(XLEN-16){instr[15]}}, instr[15:0]};

  core_decode u_dec (.op(op), .ctl(ctl));

  core_regfile #(.W(XLEN), .NREGS(32)) u_rf (
    .clk(clk), .rst(rst),
    .rd_a_idx(ra_f), .rd_b_idx(ctl.rb_is_rc ? rc_f : rb_f),
    .rd_a(ra_val), .rd_b(rb_val),
    .wr_en(ctl.reg_we), .wr_idx(rc_f), .wr_data(wb_data)
  );

  assign alu_b = ctl.use_const ? imm : rb_val;
  core_alu #(.W(XLEN)) u_alu (.fn(ctl.fn), .a(ra_val), .b(alu_b), .y(alu_y));

  assign ld_val   = dmem[alu_y[DAW+1:2]];
  assign pc_plus4 = pc + XLEN'(4);
  assign taken    = ctl.is_br && ((ra_val == '0) == ctl.br_on_zero);

  always_comb begin
    if (ctl.is_jmp)  pc_next = {ra_val[XLEN-1:2], 2'b00};
    else if (taken)  pc_next = pc_plus4 + {imm[XLEN-3:0], 2'b00};
    else             pc_next = pc_plus4;
  end

  assign wb_data = (ctl.is_br || ctl.is_jmp) ? pc_plus4 : (ctl.mem_rd ? ld_val : alu_y);
  assign wb_en   = ctl.reg_we && (rc_f != 5'd31);
  assign wb_idx  = rc_f;
  assign st_en   = ctl.mem_wr;
  assign st_addr = alu_y;
  assign st_data = rb_val;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (st_en) begin
      dmem[alu_y[DAW+1:2]] <= rb_val;
    end
  end

  // R6: reset forces PC to zero
  p_reset_pc_r6: assert property (@(posedge clk) rst |=> pc == '0);
  // R6: straight-line instructions step by one word
  p_seq_pc_r6: assert property (@(posedge clk) disable iff (rst)
    (!ctl.is_br && !ctl.is_jmp) |=> pc == $past(pc) + XLEN'(4));
  // R8: PC never leaves word alignment
  p_pc_aligned_r8: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);
  // R4: reading register 31 yields zero
  p_zero_reg_r4: assert property (@(posedge clk) disable iff (rst)
    (ra_f == 5'd31) |-> ra_val == '0);
  // R9: an unknown opcode commits nothing
  p_bad_op_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl.legal |-> (!wb_en && !st_en));
  // R7: branches link the following address
  p_link_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl.is_br && wb_en) |-> wb_data == pc + XLEN'(4));
  // R10: no program load once running
  p_no_load_r10: assert property (@(posedge clk) disable iff (rst) !load_ready);
endmodule

// File: tb/sim_word_core.sv
module sim_word_core;
  localparam int IW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_idx;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  word_core #(.XLEN(32), .IMEM_WORDS(IW), .DMEM_WORDS(64)) u0 (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data), .pc(pc), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data), .st_en(st_en), .st_addr(st_addr),
    .st_data(st_data));

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ei(input logic [5:0] o, input int c, input int a,
                                     input logic [15:0] k);
    return {o, 5'(c), 5'(a), k};
  endfunction
  function automatic logic [31:0] er(input logic [5:0] o, input int c, input int a,
                                     input int b);
    return {o, 5'(c), 5'(a), 5'(b), 11'd0};
  endfunction

  logic [31:0] prog [IW];
  logic [31:0] mr   [32];
  logic [31:0] md   [64];
  logic [31:0] mpc;
  logic [31:0] fact_seen;

  initial begin
    for (int i = 0; i < IW; i++) prog[i] = 32'h0;
    prog[0]  = ei(6'b110000, 1, 31, 16'd7);
    prog[1]  = ei(6'b110000, 2, 31, 16'hFFFD);
    prog[2]  = 32'h80611000;
    prog[3]  = er(6'b100001, 4, 1, 2);
    prog[4]  = er(6'b100010, 5, 1, 2);
    prog[5]  = ei(6'b110001, 6, 1, 16'd100);
    prog[6]  = ei(6'b110010, 7, 2, 16'hFFFB);
    prog[7]  = ei(6'b011001, 5, 31, 16'd8);
    prog[8]  = ei(6'b011000, 8, 31, 16'd8);
    prog[9]  = ei(6'b110000, 31, 1, 16'd5);
    prog[10] = er(6'b100000, 9, 31, 31);
    prog[11] = ei(6'b110000, 10, 31, 16'd1);
    prog[12] = ei(6'b110000, 11, 31, 16'd5);
    prog[13] = er(6'b100010, 10, 10, 11);
    prog[14] = ei(6'b110001, 11, 11, 16'd1);
    prog[15] = ei(6'b011101, 12, 11, 16'hFFFD);
    prog[16] = ei(6'b011100, 13, 31, 16'd1);
    prog[17] = ei(6'b110000, 14, 31, 16'd99);
    prog[18] = ei(6'b110000, 15, 31, 16'd83);
    prog[19] = ei(6'b011011, 16, 15, 16'd0);
    prog[20] = 32'hFC00_0000;
    prog[21] = ei(6'b011100, 17, 1, 16'd5);
    prog[22] = ei(6'b011100, 31, 31, 16'hFFFF);
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] ins, a, b, k, ea, exp_pc, exp_wd;
    logic [5:0]  o;
    int          c, ra, rb;
    logic        e_wen, e_st;
    string       tag;

    // preload through the stream port while reset is held
    for (int i = 0; i < IW; i++) begin
      @(negedge clk);
      chk(load_ready === 1'b1, "R10", "load_ready in reset", {31'd0, load_ready}, 32'd1);
      load_valid = 1'b1; load_addr = 6'(i); load_data = prog[i];
    end
    @(negedge clk);
    load_valid = 1'b0;
    chk(pc === 32'd0, "R6", "pc in reset", pc, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) mr[i] = '0;
    for (int i = 0; i < 64; i++) md[i] = '0;
    mpc = 0;
    fact_seen = 0;
    #1;
    chk(load_ready === 1'b0, "R10", "load_ready after reset", {31'd0, load_ready}, 32'd0);
    // an offered word after reset must not land: word 20 stays the unknown op
    load_valid = 1'b1; load_addr = 6'd20; load_data = ei(6'b110000, 20, 31, 16'd1);

    for (int cyc = 0; cyc < 80; cyc++) begin
      ins = prog[mpc[7:2]];
      o = ins[31:26]; c = int'(ins[25:21]); ra = int'(ins[20:16]); rb = int'(ins[15:11]);
      a = (ra == 31) ? 32'd0 : mr[ra];
      k = {{16{ins[15]}}, ins[15:0]};
      b = (rb == 31) ? 32'd0 : mr[rb];
      e_wen = 1'b1; e_st = 1'b0; exp_wd = 0; exp_pc = mpc + 4; ea = 0;
      tag = "R2";
      case (o)
        6'b100000: exp_wd = a + b;
        6'b100001: exp_wd = a - b;
        6'b100010: exp_wd = a * b;
        6'b110000: begin exp_wd = a + k; tag = "R3"; end
        6'b110001: begin exp_wd = a - k; tag = "R3"; end
        6'b110010: begin exp_wd = a * k; tag = "R3"; end
        6'b011000: begin ea = a + k; exp_wd = md[ea[7:2]]; tag = "R5"; end
        6'b011001: begin
          ea = a + k; e_wen = 1'b0; e_st = 1'b1; tag = "R5";
          exp_wd = (c == 31) ? 32'd0 : mr[c];
        end
        6'b011100, 6'b011101: begin
          exp_wd = mpc + 4; tag = "R7";
          if ((a == 0) == (o == 6'b011100)) exp_pc = mpc + 4 + {k[29:0], 2'b00};
        end
        6'b011011: begin exp_wd = mpc + 4; exp_pc = {a[31:2], 2'b00}; tag = "R8"; end
        default: begin e_wen = 1'b0; tag = "R9"; end
      endcase
      if (mpc == 32'd8) tag = "R1";
      if (c == 31 && e_wen) begin e_wen = 1'b0; tag = "R4"; end
      if (ra == 31 && o == 6'b100000) tag = "R4";

      chk(pc === mpc, "R6", "pc", pc, mpc);
      chk(wb_en === e_wen, tag, "wb_en", {31'd0, wb_en}, {31'd0, e_wen});
      if (e_wen) begin
        chk(wb_idx === 5'(c), tag, "wb_idx", {27'd0, wb_idx}, 32'(c));
        chk(wb_data === exp_wd, tag, "wb_data", wb_data, exp_wd);
      end
      chk(st_en === e_st, tag, "st_en", {31'd0, st_en}, {31'd0, e_st});
      if (e_st) begin
        chk(st_addr === ea, "R5", "st_addr", st_addr, ea);
        chk(st_data === exp_wd, "R5", "st_data", st_data, exp_wd);
        md[ea[7:2]] = exp_wd;
      end
      if (wb_en && wb_idx == 5'd10) fact_seen = wb_data;
      if (e_wen) mr[c] = exp_wd;
      mpc = exp_pc;
      @(negedge clk);
      #1;
    end
    load_valid = 1'b0;
    // R7: the branch loop produced 5! = 120 in r10
    chk(fact_seen === 32'd120, "R7", "loop result r10", fact_seen, 32'd120);
    // R8: jump target 83 rounded down; run ended in the self loop at 88
    chk(pc === 32'd88, "R8", "final pc", pc, 32'd88);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule